// File: doc/BRIEF.md
# Single-Shot Hit Latch

This block judges one round of a reaction game. Ten push-keys stand for the digits 0 to 9. A one-hot target vector marks the digit on show, and a window signal is high while that digit is visible. A press of the key that matches the active target line inside the window counts as a hit. The block then emits a single-cycle pulse that advances the score by one step, worth ten points, and holds a beep-enable level for the buzzer until the window ends.

Only the first qualified press in a window counts. While the window is low the hit flag is forced clear, so pressing early gains nothing. Once the flag is set, repeated presses and contact bounce are ignored until the window closes. The key inputs are asynchronous and pass through a configurable synchroniser. The target vector and the window come from logic on the same clock.

Top module: `shot_hit_latch`

## Requirements
- R1: A key counts only when its own target bit (bit i of `target_i` for key i) is high. A press of any other key produces no pulse and leaves `beep_o` low.
- R2: While `window_i` is low, `beep_o` is low and key presses have no effect. A key pressed and released before the window opens produces no hit.
- R3: Inside the window, the first rising edge of a qualified key sets the hit flag. With the default two synchroniser stages, `hit_pulse_o` is high in the third clock cycle after the key is first sampled high.
- R4: Once the flag is set, further presses of any key, including bounce, produce no additional pulse for the rest of that window.
- R5: `hit_pulse_o` lasts exactly one clock cycle, and at most one pulse occurs per window.
- R6: `beep_o` rises together with the hit pulse, stays high while the window lasts, and is low again one cycle after `window_i` is sampled low.
- R7: A qualified key that is already held when the window opens counts as a press. The pulse appears in the cycle after the window is sampled high.
- R8: Each new window allows a fresh hit, independent of the previous window.
- R9: The reset state has `hit_pulse_o` and `beep_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_i | input | N_KEYS | Raw key levels, asynchronous, high = pressed |
| target_i | input | N_KEYS | One-hot line of the digit on show |
| window_i | input | 1 | High while the digit is visible |
| hit_pulse_o | output | 1 | One-cycle score advance |
| beep_o | output | 1 | Buzzer enable, high after a hit until the window ends |

## Verification
The bench presses a wrong key inside the window, and presses and releases the right key before the window opens. A latch that ignored the target or the window would score on either. It bounces the right key and presses other keys after a hit, which shows whether a design re-arms within one window and so emits a second pulse. It holds the key across the window opening, checks the exact pulse cycle to catch a lost or extra pipeline stage, and opens a second window to find a flag that never clears.

// File: rtl/hitlatch_pkg.sv
package hitlatch_pkg;
   // smallest synchroniser depth accepted when synchronisation is enabled
   localparam int unsigned MIN_SYNC_DEPTH = 2;

   typedef enum logic {
      FLAG_ARMED = 1'b0,
      FLAG_HIT   = 1'b1
   } hit_state_e;

   function automatic logic any_match(input logic [63:0] a, input logic [63:0] b);
      return |(a & b);
   endfunction
endpackage

// File: rtl/hl_key_sync.sv
module hl_key_sync #(
   parameter int unsigned WIDTH  = 10,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o
);
   import hitlatch_pkg::*;

   initial begin
      assert (STAGES == 0 || STAGES >= MIN_SYNC_DEPTH)
         else $error("hl_key_sync: STAGES must be 0 or at least %0d", MIN_SYNC_DEPTH);
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_o = raw_i;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] stage_q;
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      stage_q[s] <= '0;
               else if (s == 0) stage_q[s] <= raw_i;
               else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
         assign sync_o = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hl_qual_edge.sv
module hl_qual_edge #(
   parameter int unsigned WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] key_s_i,
   input  logic [WIDTH-1:0] target_i,
   input  logic             window_i,
   output logic             rise_o
);
   import hitlatch_pkg::*;

   initial begin
      assert (WIDTH >= 1 && WIDTH <= 64)
         else $error("hl_qual_edge: WIDTH must lie in 1..64");
   end

   logic [63:0] key_w, tgt_w;
   logic        qual_lvl;
   logic        qual_prev_q;

   assign key_w    = 64'(key_s_i);
   assign tgt_w    = 64'(target_i);
   // gating with the window makes a held key rise when the window opens
   assign qual_lvl = window_i & any_match(key_w, tgt_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qual_prev_q <= 1'b0;
      else        qual_prev_q <= qual_lvl;
   end

   assign rise_o = qual_lvl & ~qual_prev_q;
endmodule

// File: rtl/hl_hit_flag.sv
module hl_hit_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic window_i,
   input  logic rise_i,
   output logic pulse_o,
   output logic flag_o
);
   import hitlatch_pkg::*;

   hit_state_e state_q;
   logic       flag_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   state_q <= FLAG_ARMED;
      else if (!window_i)                           state_q <= FLAG_ARMED;
      else if (rise_i && state_q == FLAG_ARMED)     state_q <= FLAG_HIT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_d_q <= 1'b0;
      else        flag_d_q <= (state_q == FLAG_HIT);
   end

   assign flag_o  = (state_q == FLAG_HIT);
   assign pulse_o = flag_o & ~flag_d_q;
endmodule

// File: rtl/shot_hit_latch.sv
module shot_hit_latch #(
   parameter int unsigned N_KEYS      = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_KEYS-1:0] key_i,
   input  logic [N_KEYS-1:0] target_i,
   input  logic              window_i,
   output logic              hit_pulse_o,
   output logic              beep_o
);
   initial begin
      assert (N_KEYS >= 1 && N_KEYS <= 64)
         else $error("shot_hit_latch: N_KEYS must lie in 1..64");
   end

   logic [N_KEYS-1:0] key_s;
   logic              qual_rise;

   hl_key_sync #(.WIDTH(N_KEYS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_i(key_i), .sync_o(key_s)
   );

   hl_qual_edge #(.WIDTH(N_KEYS)) u_qual (
      .clk(clk), .rst_n(rst_n), .key_s_i(key_s), .target_i(target_i),
      .window_i(window_i), .rise_o(qual_rise)
   );

   hl_hit_flag u_flag (
      .clk(clk), .rst_n(rst_n), .window_i(window_i), .rise_i(qual_rise),
      .pulse_o(hit_pulse_o), .flag_o(beep_o)
   );
endmodule

// File: rtl/shot_hit_latch_chk.sv
module shot_hit_latch_chk (
   input logic clk,
   input logic rst_n,
   input logic window_i,
   input logic hit_pulse_o,
   input logic beep_o
);
   // R2: closed window clears the flag on the next edge
   assert_clear_outside_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !window_i |=> !beep_o);

   // R3: the flag can only rise when the window was open
   assert_set_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(beep_o) |-> $past(window_i));

   // R4: the flag holds while the window stays open
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (beep_o && window_i) |=> beep_o);

   // R5: the pulse lasts one cycle
   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_pulse_o |=> !hit_pulse_o);

   // R5: a pulse only accompanies the flag's rise
   assert_pulse_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_pulse_o |-> $rose(beep_o));

   // R6: beep is high whenever the pulse is
   assert_beep_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_pulse_o |-> beep_o);
endmodule

bind shot_hit_latch shot_hit_latch_chk u_chk (
   .clk(clk), .rst_n(rst_n), .window_i(window_i),
   .hit_pulse_o(hit_pulse_o), .beep_o(beep_o)
);

// File: tb/sim_shot_hit_latch.sv
module sim_shot_hit_latch;
   localparam int NK = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NK-1:0] key = '0;
   logic [NK-1:0] target = '0;
   logic          window = 1'b0;
   logic          hit_pulse, beep;

   int checks = 0;
   int errors = 0;
   int pulse_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   shot_hit_latch #(.N_KEYS(NK), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .key_i(key), .target_i(target),
      .window_i(window), .hit_pulse_o(hit_pulse), .beep_o(beep)
   );

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (hit_pulse) pulse_cnt++;
      end
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic t_reset();
      check(hit_pulse == 1'b0, "R9 pulse in reset", int'(hit_pulse), 0);
      check(beep == 1'b0, "R9 beep in reset", int'(beep), 0);
   endtask

   task automatic t_wrong_key();
      pulse_cnt = 0;
      window = 1'b1; target = NK'(1) << 3;
      step(2);
      key = NK'(1) << 5;
      step(6);
      check(pulse_cnt == 0, "R1 wrong key pulses", pulse_cnt, 0);
      check(beep == 1'b0, "R1 wrong key beep", int'(beep), 0);
      key = '0; window = 1'b0;
      step(3);
   endtask

   task automatic t_early();
      pulse_cnt = 0;
      target = NK'(1) << 4;
      key = NK'(1) << 4;
      step(6);
      check(beep == 1'b0, "R2 beep while window closed", int'(beep), 0);
      key = '0;
      step(4);
      window = 1'b1;
      step(5);
      check(pulse_cnt == 0, "R2 early press scored", pulse_cnt, 0);
      check(beep == 1'b0, "R2 beep after early press", int'(beep), 0);
      window = 1'b0;
      step(2);
   endtask

   task automatic t_hit_and_bounce();
      pulse_cnt = 0;
      window = 1'b1; target = NK'(1) << 7;
      step(2);
      key = NK'(1) << 7;
      step(2);
      check(pulse_cnt == 0, "R3 pulse too early", pulse_cnt, 0);
      step(1);
      check(hit_pulse == 1'b1, "R3 pulse in third cycle", int'(hit_pulse), 1);
      check(beep == 1'b1, "R6 beep with pulse", int'(beep), 1);
      step(1);
      check(hit_pulse == 1'b0, "R5 pulse width", int'(hit_pulse), 0);
      // bounce and stray presses
      for (int b = 0; b < 4; b++) begin
         key = '0; step(2);
         key = NK'(1) << 7; step(2);
      end
      key = NK'(10'h3FF); step(4);
      check(pulse_cnt == 1, "R4 pulses after bounce", pulse_cnt, 1);
      check(beep == 1'b1, "R6 beep held in window", int'(beep), 1);
      window = 1'b0;
      step(1);
      check(beep == 1'b0, "R6 beep after window closes", int'(beep), 0);
      key = '0;
      step(4);
      check(pulse_cnt == 1, "R5 one pulse per window", pulse_cnt, 1);
   endtask

   task automatic t_held();
      pulse_cnt = 0;
      target = NK'(1) << 2;
      key = NK'(1) << 2;
      step(5);
      check(beep == 1'b0, "R7 held key before window", int'(beep), 0);
      window = 1'b1;
      step(1);
      check(hit_pulse == 1'b1, "R7 held key at window open", int'(hit_pulse), 1);
      step(3);
      check(pulse_cnt == 1, "R7 pulse count", pulse_cnt, 1);
      window = 1'b0; key = '0;
      step(3);
   endtask

   task automatic t_new_window();
      pulse_cnt = 0;
      for (int w = 0; w < 2; w++) begin
         window = 1'b1; target = NK'(1) << (w == 0 ? 9 : 0);
         step(2);
         key = NK'(10'h3FF);
         step(6);
         check(beep == 1'b1, "R1 all keys include target", int'(beep), 1);
         window = 1'b0; key = '0;
         step(3);
      end
      check(pulse_cnt == 2, "R8 fresh hit per window", pulse_cnt, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_wrong_key();
      t_early();
      t_hit_and_bounce();
      t_held();
      t_new_window();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule